// File: doc/BRIEF.md
# Binary Paper-Tape Loader Decoder

This block decodes a stream of 8-bit tape characters in the binary loader format and turns it into memory write commands. Characters arrive one at a time on a valid/ready input. Leader and trailer characters frame the load. A pair of rubout characters brackets a stretch of tape to be erased. Field-select characters choose which of eight 4096-word memory fields receives later stores. All other characters are taken in pairs to form 12-bit words. A word is either an address, which sets the store pointer, or data, which is stored at the pointer; the pointer then advances by one.

A 12-bit running sum of the raw characters of every address and data pair is kept. The last word before the trailer is a checksum, not data. Because that word cannot be told apart from data until the trailer shows up, every assembled word is held back by one pair. It is committed only when the first character of the next pair arrives. When the trailer is seen, the held word is compared with the running sum. The block then raises `done`, the pass flag and the 12-bit difference, and keeps them until reset.

Back-pressure rules: `in_ready` is low while a write command is waiting on the write port. A character moves when `in_valid` and `in_ready` are both high at a clock edge. A write moves when `wr_valid` and `wr_ready` are both high. While `wr_valid` is high and `wr_ready` is low, the write command holds steady.

Top module: `bin_tape_loader`

## Requirements
- R1: During and after a synchronous reset (`rst_n` low), `done`, `checksum_ok`, `checksum_diff` and `wr_valid` are 0 and `in_ready` is 1.
- R2: A frame character (top two bits 10, octal 0200 to 0277) arriving before the first pair has started is skipped, with no write and no `done`.
- R3: A body character (top two bits 00 or 01) starts a pair, and the next character, whatever its value, completes it. The word is ((first & 077) << 6) + second, modulo 4096. Bit 6 of the first character (octal 0100) marks an address word. An address word loads the pointer. A data word is written to {field, pointer}, and the pointer then increments.
- R4: An assembled pair is held back. Its write or address load, and its share of the sum, take effect on the clock edge that accepts the first character of the next pair, so `wr_valid` rises one cycle after that acceptance.
- R5: Octal 0377 at the start of a pair toggles an erase mode. All characters between an odd rubout and the next one are discarded, including frame and field characters.
- R6: A field character (top bits 11, not 0377) sets the field to its bits 5:3 for pairs that start after it, and is not added to the sum.
- R7: The field in use after reset is the value on `init_field` while reset is held.
- R8: On the trailer (a frame character after a pair has started), `done` rises one cycle later, `checksum_diff` = (sum − held word) mod 4096, and `checksum_ok` = 1 exactly when that difference is 0. The held word's own characters are not in the sum.
- R9: The pointer wraps from octal 7777 to 0000 within the same field.
- R10: While `wr_valid` is high and `wr_ready` low, `in_ready` is 0 and `wr_addr` and `wr_data` hold steady.
- R11: After `done`, characters are accepted and discarded, no writes are issued, and `done`, `checksum_ok` and `checksum_diff` hold steady until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init_field | input | 3 | Starting memory field, sampled during reset |
| in_valid | input | 1 | Tape character valid |
| in_ready | output | 1 | Block can take a character |
| in_char | input | 8 | Tape character |
| wr_valid | output | 1 | Write command valid |
| wr_ready | input | 1 | Memory side takes the write |
| wr_addr | output | 15 | Field and word address of the write |
| wr_data | output | 12 | Word to store |
| done | output | 1 | Trailer reached |
| checksum_ok | output | 1 | Held word matched the running sum |
| checksum_diff | output | 12 | Running sum minus held word, modulo 4096 |

## Verification
A data pair's write is due one cycle after the edge that accepts the next pair's first character. The bench therefore counts writes only after that character has been sent and two falling edges have passed. It also checks that no write has appeared after the pair itself. `done`, the flag and the difference are due one cycle after the trailer is accepted, and are sampled at the second falling edge after it. Back-pressure is checked by holding `wr_ready` low and sampling the stalled command over three cycles.

// File: rtl/bin_loader_pkg.sv
package bin_loader_pkg;
  localparam int CHAR_W  = 8;
  localparam int HALF_W  = 6;
  localparam int WORD_W  = 2 * HALF_W;
  localparam int FIELD_W = 3;
  localparam int WADDR_W = FIELD_W + WORD_W;

  typedef enum logic [1:0] {
    CH_BODY,
    CH_FRAME,
    CH_FIELD,
    CH_RUBOUT
  } char_kind_e;

  localparam logic [CHAR_W-1:0] RUBOUT_CODE = '1;
endpackage

// File: rtl/bin_char_class.sv
module bin_char_class
  import bin_loader_pkg::*;
(
  input  logic [CHAR_W-1:0] ch,
  output char_kind_e        kind
);
  always_comb begin
    unique case (ch[CHAR_W-1 -: 2])
      2'b10:   kind = CH_FRAME;
      2'b11:   kind = (ch == RUBOUT_CODE) ? CH_RUBOUT : CH_FIELD;
      default: kind = CH_BODY;
    endcase
  end
endmodule

// File: rtl/bin_pair_former.sv
module bin_pair_former
  import bin_loader_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] init_field,
  input  logic               take,
  input  logic [CHAR_W-1:0]  ch,
  input  char_kind_e         kind,
  output logic               first_pulse,
  output logic               pair_pulse,
  output logic               end_pulse,
  output logic [WORD_W-1:0]  pair_word,
  output logic               pair_link,
  output logic [WORD_W-1:0]  pair_sum,
  output logic [FIELD_W-1:0] pair_field
);
  logic               want_low;
  logic               skipping;
  logic               started;
  logic [CHAR_W-1:0]  hi_char;
  logic [FIELD_W-1:0] field_q;
  logic [FIELD_W-1:0] hi_field;
  logic               lead_pos;

  assign lead_pos    = take && !want_low && !skipping;
  assign first_pulse = lead_pos && (kind == CH_BODY);
  assign end_pulse   = lead_pos && (kind == CH_FRAME) && started;
  assign pair_pulse  = take && want_low;
  assign pair_word   = {hi_char[HALF_W-1:0], {HALF_W{1'b0}}} + WORD_W'(ch);
  assign pair_link   = hi_char[HALF_W];
  assign pair_sum    = WORD_W'(hi_char) + WORD_W'(ch);
  assign pair_field  = hi_field;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want_low <= 1'b0;
      skipping <= 1'b0;
      started  <= 1'b0;
      hi_char  <= '0;
      field_q  <= init_field;
      hi_field <= init_field;
    end else if (take) begin
      if (want_low) begin
        want_low <= 1'b0;
      end else if (skipping) begin
        if (kind == CH_RUBOUT) skipping <= 1'b0;
      end else begin
        unique case (kind)
          CH_RUBOUT: skipping <= 1'b1;
          CH_FIELD:  field_q  <= ch[HALF_W-1 -: FIELD_W];
          CH_BODY: begin
            hi_char  <= ch;
            hi_field <= field_q;
            want_low <= 1'b1;
            started  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bin_commit.sv
module bin_commit
  import bin_loader_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               first_pulse,
  input  logic               pair_pulse,
  input  logic               end_pulse,
  input  logic [WORD_W-1:0]  pair_word,
  input  logic               pair_link,
  input  logic [WORD_W-1:0]  pair_sum,
  input  logic [FIELD_W-1:0] pair_field,
  input  logic               wr_ready,
  output logic               wr_valid,
  output logic [WADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0]  wr_data,
  output logic               done,
  output logic               sum_ok,
  output logic [WORD_W-1:0]  sum_diff
);
  logic               pend_valid;
  logic [WORD_W-1:0]  pend_word;
  logic               pend_link;
  logic [WORD_W-1:0]  pend_sum;
  logic [FIELD_W-1:0] pend_field;
  logic [WORD_W-1:0]  ptr;
  logic [WORD_W-1:0]  run_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_word  <= '0;
      pend_link  <= 1'b0;
      pend_sum   <= '0;
      pend_field <= '0;
      ptr        <= '0;
      run_sum    <= '0;
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      done       <= 1'b0;
      sum_ok     <= 1'b0;
      sum_diff   <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (first_pulse && pend_valid) begin
        run_sum    <= run_sum + pend_sum;
        pend_valid <= 1'b0;
        if (pend_link) begin
          ptr <= pend_word;
        end else begin
          wr_valid <= 1'b1;
          wr_addr  <= {pend_field, ptr};
          wr_data  <= pend_word;
          ptr      <= ptr + 1'b1;
        end
      end
      if (pair_pulse) begin
        pend_valid <= 1'b1;
        pend_word  <= pair_word;
        pend_link  <= pair_link;
        pend_sum   <= pair_sum;
        pend_field <= pair_field;
      end
      if (end_pulse) begin
        done     <= 1'b1;
        sum_diff <= run_sum - pend_word;
        sum_ok   <= (run_sum == pend_word);
      end
    end
  end
endmodule

// File: rtl/bin_tape_loader.sv
module bin_tape_loader
  import bin_loader_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] init_field,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CHAR_W-1:0]  in_char,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [WADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0]  wr_data,
  output logic               done,
  output logic               checksum_ok,
  output logic [WORD_W-1:0]  checksum_diff
);
  char_kind_e         kind;
  logic               take;
  logic               first_pulse;
  logic               pair_pulse;
  logic               end_pulse;
  logic [WORD_W-1:0]  pair_word;
  logic               pair_link;
  logic [WORD_W-1:0]  pair_sum;
  logic [FIELD_W-1:0] pair_field;

  assign in_ready = !wr_valid;
  assign take     = in_valid && in_ready && !done;

  bin_char_class i_class (
    .ch   (in_char),
    .kind (kind)
  );

  bin_pair_former i_former (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_field  (init_field),
    .take        (take),
    .ch          (in_char),
    .kind        (kind),
    .first_pulse (first_pulse),
    .pair_pulse  (pair_pulse),
    .end_pulse   (end_pulse),
    .pair_word   (pair_word),
    .pair_link   (pair_link),
    .pair_sum    (pair_sum),
    .pair_field  (pair_field)
  );

  bin_commit i_commit (
    .clk         (clk),
    .rst_n       (rst_n),
    .first_pulse (first_pulse),
    .pair_pulse  (pair_pulse),
    .end_pulse   (end_pulse),
    .pair_word   (pair_word),
    .pair_link   (pair_link),
    .pair_sum    (pair_sum),
    .pair_field  (pair_field),
    .wr_ready    (wr_ready),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .done        (done),
    .sum_ok      (checksum_ok),
    .sum_diff    (checksum_diff)
  );
endmodule

// File: rtl/bin_tape_loader_chk.sv
module bin_tape_loader_chk
  import bin_loader_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [WADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0]  wr_data,
  input logic               done,
  input logic               checksum_ok,
  input logic [WORD_W-1:0]  checksum_diff
);
  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_result_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(checksum_ok) && $stable(checksum_diff));

  assert_no_write_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !wr_valid);

  assert_ok_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    checksum_ok |-> done);

  assert_write_from_char_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid ##1 wr_valid |-> $past(in_valid && in_ready));
endmodule

bind bin_tape_loader bin_tape_loader_chk i_chk (.*);

// File: tb/test_bin_tape_loader.sv
module test_bin_tape_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  init_field = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  in_char = 0;
  logic        wr_valid;
  logic        wr_ready = 1;
  logic [14:0] wr_addr;
  logic [11:0] wr_data;
  logic        done;
  logic        checksum_ok;
  logic [11:0] checksum_diff;

  int checks = 0;
  int errors = 0;
  int exp_sum = 0;
  int got_n = 0;
  int exp_n = 0;
  int cycles = 0;
  bit finished = 0;
  logic [14:0] got_addr [0:15];
  logic [11:0] got_data [0:15];
  logic [14:0] exp_addr [0:15];
  logic [11:0] exp_data [0:15];

  bin_tape_loader i_bin_tape_loader (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready && got_n < 16) begin
      got_addr[got_n] = wr_addr;
      got_data[got_n] = wr_data;
      got_n++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] f);
    init_field = f;
    rst_n = 0;
    settle(2);
    rst_n = 1;
    exp_sum = 0; got_n = 0; exp_n = 0;
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    in_valid = 1; in_char = c;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic put_pair(input logic [7:0] a, input logic [7:0] b);
    send(a); send(b);
    exp_sum = (exp_sum + a + b) % 4096;
  endtask

  task automatic put_addr(input logic [11:0] a);
    put_pair({2'b01, a[11:6]}, {2'b00, a[5:0]});
  endtask

  task automatic put_data(input logic [11:0] d);
    put_pair({2'b00, d[11:6]}, {2'b00, d[5:0]});
  endtask

  task automatic put_cs(input logic [11:0] w);
    send({2'b00, w[11:6]}); send({2'b00, w[5:0]});
  endtask

  task automatic expect_wr(input logic [2:0] f, input logic [11:0] a, input logic [11:0] d);
    exp_addr[exp_n] = {f, a};
    exp_data[exp_n] = d;
    exp_n++;
  endtask

  task automatic cmp_writes(input string req);
    chk(got_n == exp_n, {req, " write count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_addr[i] == exp_addr[i], {req, " write address"}, got_addr[i], exp_addr[i]);
      chk(got_data[i] == exp_data[i], {req, " write data"}, got_data[i], exp_data[i]);
    end
  endtask

  initial begin
    logic [14:0] held_a;
    logic [11:0] held_d;
    logic [11:0] cs;
    // R1: reset state
    do_reset(3'd5);
    settle(1);
    chk(done == 0 && checksum_ok == 0, "R1 done/ok", {done, checksum_ok}, 0);
    chk(checksum_diff == 0, "R1 diff", checksum_diff, 0);
    chk(wr_valid == 0 && in_ready == 1, "R1 handshake", {wr_valid, in_ready}, 1);

    // R2: leader skipped
    send(8'o200); send(8'o200); send(8'o277);
    settle(2);
    chk(got_n == 0, "R2 no write on leader", got_n, 0);
    chk(done == 0, "R2 no done on leader", done, 0);

    // R3 R4 R7 R9: pairs, deferral, init field, wrap
    put_addr(12'o7776);
    put_data(12'o1234);
    settle(2);
    chk(got_n == 0, "R4 data held one pair", got_n, 0);
    put_data(12'o4321);
    settle(2);
    chk(got_n == 1, "R4 commit on next pair", got_n, 1);
    put_data(12'o0077);
    cs = exp_sum[11:0];
    put_cs(cs);
    send(8'o200);
    settle(2);
    chk(done == 1, "R8 done on trailer", done, 1);
    chk(checksum_ok == 1, "R8 checksum match", checksum_ok, 1);
    chk(checksum_diff == 0, "R8 diff zero", checksum_diff, 0);
    expect_wr(3'd5, 12'o7776, 12'o1234);
    expect_wr(3'd5, 12'o7777, 12'o4321);
    expect_wr(3'd5, 12'o0000, 12'o0077);
    cmp_writes("R3 R7 R9");

    // R11: after done, input discarded
    put_data(12'o0101); send(8'o001); send(8'o200);
    settle(2);
    chk(got_n == 3, "R11 no write after done", got_n, 3);
    chk(done == 1 && checksum_ok == 1 && checksum_diff == 0, "R11 result held",
        {done, checksum_ok}, 3);

    // R5 R6 R8: sweep over fields with erased stretches and checksum errors
    for (int f = 0; f < 8; f++) begin
      logic [11:0] d1, d2;
      do_reset(3'd0);
      d1 = 12'(f * 12'o1111);
      d2 = 12'o7000 + 12'(f);
      send(8'o200);
      send(8'(8'o300 | (f << 3)));
      put_addr(12'o0100 + 12'(f));
      put_data(d1);
      send(8'o377); send(8'o012); send(8'o200); send(8'o310); send(8'o377);
      put_data(d2);
      cs = (f % 2 == 0) ? exp_sum[11:0] : exp_sum[11:0] + 12'd1;
      put_cs(cs);
      send(8'o200);
      settle(2);
      chk(done == 1, "R8 sweep done", done, 1);
      chk(checksum_ok == (f % 2 == 0), "R8 sweep ok flag", checksum_ok, (f % 2 == 0));
      chk(checksum_diff == ((f % 2 == 0) ? 12'o0 : 12'o7777), "R8 sweep diff",
          checksum_diff, (f % 2 == 0) ? 0 : 4095);
      expect_wr(3'(f), 12'o0100 + 12'(f), d1);
      expect_wr(3'(f), 12'o0101 + 12'(f), d2);
      cmp_writes("R5 R6");
    end

    // R10: back-pressure
    do_reset(3'd2);
    wr_ready = 0;
    put_addr(12'o0000);
    put_data(12'o5555);
    send(8'o066);
    settle(2);
    chk(wr_valid == 1, "R10 write pending", wr_valid, 1);
    chk(in_ready == 0, "R10 input stalled", in_ready, 0);
    held_a = wr_addr; held_d = wr_data;
    settle(3);
    chk(wr_addr == held_a && wr_data == held_d, "R10 command stable", wr_data, held_d);
    chk(in_ready == 0, "R10 still stalled", in_ready, 0);
    wr_ready = 1;
    send(8'o066);
    exp_sum = (exp_sum + 8'o066 + 8'o066) % 4096;
    cs = exp_sum[11:0];
    put_cs(cs);
    send(8'o277);
    settle(2);
    chk(done == 1 && checksum_ok == 1, "R10 load completes", {done, checksum_ok}, 3);
    expect_wr(3'd2, 12'o0000, 12'o5555);
    expect_wr(3'd2, 12'o0001, 12'o6666);
    cmp_writes("R10");

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule